// File: doc/BRIEF.md
# Calendar Timekeeper with Coherent Access Registers

This block keeps wall-clock time and date for a chip that runs from a 32.768 kHz time base. A prescaler divides the incoming clock to one count per second. Each second advances a calendar core held in BCD: seconds, minutes, hours in 24-hour form, day of the week, day of the month, month and two-digit year. The calendar knows how long each month is and counts February 29 in every year divisible by four.

Software never touches the core directly. A bank of seven holding bytes sits between the core and a small byte-wide register port. A control byte at address 0 carries two bits. The freeze bit takes a consistent picture of the core and holds it while software reads the fields one at a time. The lock bit stops the core and lets software place a new time in the holding bytes. Clearing the lock bit commits all seven bytes to the core in one cycle and restarts the second count from zero.

If the core is about to advance in the same cycle that the freeze bit is raised, the picture shows the advanced time, so a read never mixes a stale field with a fresh one.

Top module: `rtc_sync_core`

## Requirements
- R1: After reset the control byte reads 0x00 and the holding bytes read seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00.
- R2: While unlocked, the core advances by one second on exactly every DIV-th clock. After reset or after a lock release, the first advance comes on the DIV-th rising edge.
- R3: Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00 and carry into the day.
- R4: Day of week counts 1 to 7 and wraps from 07 to 01 at midnight.
- R5: Dates wrap after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12. Month 12 wraps to 01 and carries into the year.
- R6: February wraps after 29 when the year is divisible by four (00 counts as such) and after 28 otherwise. Year 99 wraps to 00.
- R7: While the freeze bit and the lock bit are both 0, each holding byte shows the core value from the same edge.
- R8: A write that raises the freeze bit in the same cycle as a second advance captures the advanced time.
- R9: While the freeze bit is 1 and the lock bit is 0, the holding bytes do not change, even though the core keeps counting.
- R10: While the lock bit is 1, the core does not advance and writes to addresses 1 to 7 load the holding bytes. While the lock bit is 0, such writes are ignored.
- R11: The write that clears the lock bit copies all holding bytes into the core on that edge and restarts the second count from zero.
- R12: Register map. Address 0 is control, with bit 0 the freeze bit and bit 1 the lock bit. Addresses 1 to 7 hold seconds, minutes, hours, day of week, date, month and year, in that order, in packed BCD. Any other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock (32.768 kHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | 8 | Read data, combinational from the holding bytes or control |

## Verification
A corrupted core value reaches the ports within one edge whenever neither control bit is set, because the holding bytes mirror the core. A bad carry only shows at a rollover, so the test drives the calendar up to every wrap boundary explicitly. A prescaler that is off by one shifts the second boundary by a single clock. A missed restart on lock release shows up DIV edges later. A broken freeze shows up within one second, as a holding byte that moves while it should be frozen.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    localparam int unsigned FIELD_N = 7;

    localparam int unsigned F_SEC   = 0;
    localparam int unsigned F_MIN   = 1;
    localparam int unsigned F_HOUR  = 2;
    localparam int unsigned F_DOW   = 3;
    localparam int unsigned F_DATE  = 4;
    localparam int unsigned F_MONTH = 5;
    localparam int unsigned F_YEAR  = 6;

    localparam int unsigned CTL_FRZ_BIT  = 0;
    localparam int unsigned CTL_LOCK_BIT = 1;

    // Field i lives at register address i+1.
    typedef logic [FIELD_N-1:0][7:0] rtc_time_t;

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
        logic [7:0] t;
        logic [7:0] o;
        t = v / 8'd10;
        o = v % 8'd10;
        return {t[3:0], o[3:0]};
    endfunction

    function automatic logic [7:0] field_lo(input int unsigned idx);
        case (idx)
            F_DOW, F_DATE, F_MONTH: return 8'd1;
            default:                return 8'd0;
        endcase
    endfunction

    function automatic logic [7:0] field_hi(input int unsigned idx);
        case (idx)
            F_SEC, F_MIN: return 8'd59;
            F_HOUR:       return 8'd23;
            F_DOW:        return 8'd7;
            F_DATE:       return 8'd31;
            F_MONTH:      return 8'd12;
            default:      return 8'd99;
        endcase
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] mon_bin,
                                              input logic [7:0] yr_bin);
        case (mon_bin)
            8'd2:                      return (yr_bin[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction

    function automatic rtc_time_t time_reset();
        rtc_time_t t;
        t = '0;
        t[F_DOW]   = 8'h01;
        t[F_DATE]  = 8'h01;
        t[F_MONTH] = 8'h01;
        return t;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
    parameter int unsigned DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick,
    output logic idle
);

    localparam int unsigned    CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0]  LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } presc_t;

    presc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = !hold && (st_q.cnt == LAST);
        if (hold || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle = (st_q.cnt == '0);

endmodule

// File: rtl/rtc_bcd_field.sv
`timescale 1ns/1ps
module rtc_bcd_field
    import rtc_pkg::*;
(
    input  logic [7:0] cur_bcd,
    input  logic [7:0] lo,
    input  logic [7:0] hi,
    input  logic       inc,
    output logic [7:0] nxt_bcd,
    output logic       wrap
);

    logic [7:0] val;

    always_comb begin
        val     = bcd_to_bin(cur_bcd);
        wrap    = inc && (val >= hi);
        nxt_bcd = cur_bcd;
        if (inc) begin
            nxt_bcd = (val >= hi) ? bin_to_bcd(lo) : bin_to_bcd(val + 8'd1);
        end
    end

endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      tick,
    output rtc_time_t nxt
);

    logic [7:0] dim;

    assign dim = month_days(bcd_to_bin(cur[F_MONTH]), bcd_to_bin(cur[F_YEAR]));

    for (genvar i = 0; i < FIELD_N; i++) begin : g_field
        logic       inc_i;
        logic       wrap_i;
        logic [7:0] hi_i;

        if (i == F_SEC) begin : g_src
            assign inc_i = tick;
        end else if (i == F_DOW || i == F_DATE) begin : g_src
            assign inc_i = g_field[F_HOUR].wrap_i;
        end else if (i == F_MONTH) begin : g_src
            assign inc_i = g_field[F_DATE].wrap_i;
        end else if (i == F_YEAR) begin : g_src
            assign inc_i = g_field[F_MONTH].wrap_i;
        end else begin : g_src
            assign inc_i = g_field[i-1].wrap_i;
        end

        if (i == F_DATE) begin : g_lim
            assign hi_i = dim;
        end else begin : g_lim
            assign hi_i = field_hi(i);
        end

        rtc_bcd_field u_field (
            .cur_bcd (cur[i]),
            .lo      (field_lo(i)),
            .hi      (hi_i),
            .inc     (inc_i),
            .nxt_bcd (nxt[i]),
            .wrap    (wrap_i)
        );
    end

endmodule

// File: rtl/rtc_sync_core.sv
`timescale 1ns/1ps
module rtc_sync_core
    import rtc_pkg::*;
#(
    parameter int unsigned DIV = 32768,
    parameter int unsigned AW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    typedef struct packed {
        logic      frz;
        logic      lock;
        rtc_time_t core;
        rtc_time_t hold;
    } sync_t;

    sync_t     st_d, st_q;
    logic      tick;
    logic      presc_idle;
    rtc_time_t core_step;
    logic      ctl_wr;

    // Exposed for the bound checker.
    logic      r_q;
    logic      w_q;
    rtc_time_t core_q;
    rtc_time_t hold_q;

    rtc_prescaler #(.DIV(DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (st_q.lock),
        .tick  (tick),
        .idle  (presc_idle)
    );

    rtc_calendar u_cal (
        .cur  (st_q.core),
        .tick (tick),
        .nxt  (core_step)
    );

    always_comb begin
        st_d   = st_q;
        ctl_wr = wr_en && (wr_addr == '0);
        if (st_q.lock) begin
            if (ctl_wr && !wr_data[CTL_LOCK_BIT]) begin
                st_d.core = st_q.hold;
            end
            for (int i = 0; i < FIELD_N; i++) begin
                if (wr_en && (wr_addr == AW'(i + 1))) begin
                    st_d.hold[i] = wr_data;
                end
            end
        end else begin
            st_d.core = core_step;
            if (!st_q.frz) begin
                st_d.hold = core_step;
            end
        end
        if (ctl_wr) begin
            st_d.frz  = wr_data[CTL_FRZ_BIT];
            st_d.lock = wr_data[CTL_LOCK_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.frz  <= 1'b0;
            st_q.lock <= 1'b0;
            st_q.core <= time_reset();
            st_q.hold <= time_reset();
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_addr == '0) begin
            rd_data[CTL_FRZ_BIT]  = st_q.frz;
            rd_data[CTL_LOCK_BIT] = st_q.lock;
        end
        for (int i = 0; i < FIELD_N; i++) begin
            if (rd_addr == AW'(i + 1)) begin
                rd_data = st_q.hold[i];
            end
        end
    end

    assign r_q    = st_q.frz;
    assign w_q    = st_q.lock;
    assign core_q = st_q.core;
    assign hold_q = st_q.hold;

endmodule

// File: rtl/rtc_sync_core_chk.sv
`timescale 1ns/1ps
module rtc_sync_core_chk
    import rtc_pkg::*;
#(
    parameter int unsigned AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [7:0]    wr_data,
    input logic          r_q,
    input logic          w_q,
    input logic          tick,
    input logic          presc_idle,
    input rtc_time_t     core_q,
    input rtc_time_t     hold_q
);

    logic release_wr;
    assign release_wr = wr_en && (wr_addr == '0) && w_q && !wr_data[CTL_LOCK_BIT];

    // R7
    mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q && !w_q) |=> (hold_q == core_q));

    // R9
    freeze_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q && !w_q) |=> $stable(hold_q));

    // R10
    core_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q && !release_wr) |=> $stable(core_q));

    // R11
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_wr |=> (core_q == $past(hold_q)));

    // R11
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_wr |=> presc_idle);

    // R2
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> presc_idle);

    // R10
    no_tick_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q && !release_wr) |=> !$past(tick));

endmodule

bind rtc_sync_core rtc_sync_core_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .r_q        (r_q),
    .w_q        (w_q),
    .tick       (tick),
    .presc_idle (presc_idle),
    .core_q     (core_q),
    .hold_q     (hold_q)
);

// File: tb/rtc_sync_core_bench.sv
`timescale 1ns/1ps
module rtc_sync_core_bench;

    localparam int unsigned DIV = 4;
    localparam int unsigned AW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = 8'h00;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int checks = 0;
    int errors = 0;

    rtc_sync_core #(.DIV(DIV), .AW(AW)) u_rtc_sync_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always #4 clk = ~clk;

    // Behavioural reference: binary integers, index 0 sec .. 6 year.
    int mc[7] = '{0, 0, 0, 1, 1, 1, 0};
    int mh[7] = '{0, 0, 0, 1, 1, 1, 0};
    int nc[7];
    int nh[7];
    int m_cnt = 0;
    bit m_r = 0;
    bit m_w = 0;
    bit m_tick;
    bit m_ctl;
    bit m_rel;

    function automatic int mdays(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    task automatic advance_nc();
        nc[0]++;
        if (nc[0] == 60) begin
            nc[0] = 0; nc[1]++;
            if (nc[1] == 60) begin
                nc[1] = 0; nc[2]++;
                if (nc[2] == 24) begin
                    nc[2] = 0;
                    nc[3] = (nc[3] == 7) ? 1 : nc[3] + 1;
                    nc[4]++;
                    if (nc[4] > mdays(nc[5], nc[6])) begin
                        nc[4] = 1; nc[5]++;
                        if (nc[5] == 13) begin
                            nc[5] = 1;
                            nc[6] = (nc[6] + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mc = '{0, 0, 0, 1, 1, 1, 0};
            mh = '{0, 0, 0, 1, 1, 1, 0};
            m_cnt = 0; m_r = 0; m_w = 0;
        end else begin
            m_ctl  = wr_en && (wr_addr == 0);
            m_rel  = m_ctl && m_w && !wr_data[1];
            m_tick = !m_w && (m_cnt == DIV - 1);
            nc = mc;
            nh = mh;
            if (m_w) begin
                if (m_rel) nc = mh;
                if (wr_en && wr_addr >= 1 && wr_addr <= 7) nh[int'(wr_addr) - 1] = from_bcd(wr_data);
                m_cnt = 0;
            end else begin
                if (m_tick) advance_nc();
                m_cnt = m_tick ? 0 : m_cnt + 1;
                if (!m_r) nh = nc;
            end
            mc = nc;
            mh = nh;
            if (m_ctl) begin
                m_r = wr_data[0];
                m_w = wr_data[1];
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        rd_addr = AW'(a);
        #0.1;
        v = rd_data;
    endtask

    task automatic expect_reg(input string req, input int a, input logic [7:0] e);
        logic [7:0] v;
        rd(a, v);
        check(req, v, e);
    endtask

    // R12 model comparison of every address on every clock
    task automatic compare_all();
        logic [7:0] v;
        logic [7:0] e;
        for (int a = 0; a < 9; a++) begin
            rd(a, v);
            if (a == 0) e = {6'b0, m_w, m_r};
            else if (a <= 7) e = to_bcd(mh[a - 1]);
            else e = 8'h00;
            check("R12 model", v, e);
        end
    endtask

    task automatic cyc(input logic we, input int a, input logic [7:0] d);
        wr_en = we; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 0, 8'h00);
    endtask

    task automatic set_time(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                            input logic [7:0] dw, input logic [7:0] hr, input logic [7:0] mi,
                            input logic [7:0] se);
        cyc(1'b1, 0, 8'h02);
        cyc(1'b1, 1, se);
        cyc(1'b1, 2, mi);
        cyc(1'b1, 3, hr);
        cyc(1'b1, 4, dw);
        cyc(1'b1, 5, dt);
        cyc(1'b1, 6, mo);
        cyc(1'b1, 7, yr);
        cyc(1'b1, 0, 8'h00);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all();
        // R1 reset state
        expect_reg("R1 ctl", 0, 8'h00);
        expect_reg("R1 sec", 1, 8'h00);
        expect_reg("R1 dow", 4, 8'h01);
        expect_reg("R1 date", 5, 8'h01);
        expect_reg("R1 month", 6, 8'h01);
        expect_reg("R1 year", 7, 8'h00);

        // R2 one second per DIV clocks, R3 minute carry
        idle(DIV * 61 - 1);
        expect_reg("R2 sec before", 1, 8'h00);
        idle(1);
        expect_reg("R2 sec", 1, 8'h01);
        expect_reg("R3 min", 2, 8'h01);

        // R3 R4 R6 non-leap February end, midnight, dow wrap
        set_time(8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59);
        idle(DIV - 1);
        expect_reg("R11 no early tick", 1, 8'h59);
        idle(1);
        expect_reg("R3 sec wrap", 1, 8'h00);
        expect_reg("R3 min wrap", 2, 8'h00);
        expect_reg("R3 hour wrap", 3, 8'h00);
        expect_reg("R4 dow wrap", 4, 8'h01);
        expect_reg("R6 date", 5, 8'h01);
        expect_reg("R6 month", 6, 8'h03);

        // R6 leap year Feb 28 -> 29 -> Mar 1
        set_time(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        idle(DIV);
        expect_reg("R6 leap date", 5, 8'h29);
        expect_reg("R4 dow inc", 4, 8'h04);
        set_time(8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
        idle(DIV);
        expect_reg("R6 leap end", 5, 8'h01);
        expect_reg("R6 leap month", 6, 8'h03);

        // R5 R6 year end
        set_time(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        idle(DIV);
        expect_reg("R6 year wrap", 7, 8'h00);
        expect_reg("R5 month wrap", 6, 8'h01);
        expect_reg("R5 date", 5, 8'h01);

        // R5 30 and 31 day months
        set_time(8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        idle(DIV);
        expect_reg("R5 apr end", 6, 8'h05);
        set_time(8'h24, 8'h01, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        idle(DIV);
        expect_reg("R5 jan 31", 5, 8'h31);

        // R10 field writes ignored while unlocked
        set_time(8'h24, 8'h06, 8'h10, 8'h01, 8'h12, 8'h00, 8'h00);
        cyc(1'b1, 1, 8'h45);
        expect_reg("R10 ignored", 1, 8'h00);

        // R9 freeze, then R7 tracking after release
        set_time(8'h24, 8'h06, 8'h10, 8'h01, 8'h12, 8'h00, 8'h10);
        cyc(1'b1, 0, 8'h01);
        expect_reg("R12 ctl frz", 0, 8'h01);
        idle(12);
        expect_reg("R9 frozen", 1, 8'h10);
        cyc(1'b1, 0, 8'h00);
        idle(1);
        expect_reg("R7 tracks", 1, 8'h13);

        // R8 freeze raised on the advancing edge
        set_time(8'h24, 8'h06, 8'h10, 8'h01, 8'h12, 8'h00, 8'h20);
        idle(DIV - 1);
        cyc(1'b1, 0, 8'h01);
        idle(2 * DIV);
        expect_reg("R8 snapshot", 1, 8'h21);
        cyc(1'b1, 0, 8'h00);
        idle(1);
        expect_reg("R7 resync", 1, 8'h23);

        // R10 core frozen while locked, R11 restart
        set_time(8'h24, 8'h06, 8'h10, 8'h01, 8'h12, 8'h00, 8'h30);
        idle(2);
        cyc(1'b1, 0, 8'h02);
        expect_reg("R12 ctl lock", 0, 8'h02);
        idle(20);
        expect_reg("R10 locked", 1, 8'h30);
        cyc(1'b1, 0, 8'h00);
        idle(DIV - 1);
        expect_reg("R11 restart", 1, 8'h30);
        idle(1);
        expect_reg("R11 first tick", 1, 8'h31);
        expect_reg("R12 unmapped", 9, 8'h00);

        report();
    end

endmodule